// File: doc/BRIEF.md
# Indexed Framebuffer Burst Writer

This block takes coloured pixels from a rendering pipeline in whatever order they finish. Each pixel arrives as one 32-bit packed RGB word together with its linear position in the frame. The block stores each pixel at `base + index*4` in a memory-resident framebuffer, using an AXI4 write master with its address, data and response channels. No reorder stage is used: memory itself serves as the ordering point, and the display side reads the buffer independently.

When pixels with rising, back-to-back indices arrive one after another, the block gathers them into a short incrementing burst. A group is closed and issued in any of these cases:
- the next index is not the successor of the last one,
- the beat limit is reached,
- the next word would start a new 4 KB page,
- the input has been quiet for a programmable number of cycles.

The base address is taken when the first pixel of a group is accepted. Software can therefore switch between two buffers, and the switch takes effect only at a burst boundary. The block counts responses still outstanding and keeps a sticky error flag. It reports completion only when every response has come back clean.

Top module: `fb_burst_writer`

## Requirements
- R1: Each pixel is written as one full word. The address is `cfg_base + pix_index*4`, with `cfg_base` word aligned. Every burst uses a 4-byte beat (`m_awsize` = 3'b010) and INCR type (`m_awburst` = 2'b01), and `m_wstrb` = 4'b1111 on every beat.
- R2: A pixel whose index equals the previous accepted index plus one joins the open group. A group of N pixels is issued as one burst with `m_awlen` = N-1. Its beats carry the pixels in acceptance order.
- R3: A pixel whose index does not follow on closes the open group, and that pixel opens the next group. Pixels in any order each land at their own address, and write data leaves in acceptance order.
- R4: No burst exceeds MAX_BEATS (default 16) beats. A longer consecutive run is split, so 20 consecutive indices give bursts of 16 and 4 beats.
- R5: No burst crosses a PAGE_BYTES (4096) boundary. A group closes as soon as its next address would be page aligned.
- R6: An open group with no further pixel accepted is issued after `cfg_idle_cycles` idle cycles, and not earlier.
- R7: Each burst sends exactly `m_awlen`+1 write beats after its address handshake. `m_wlast` is high on the final beat only.
- R8: While `m_awvalid` or `m_wvalid` waits for its ready, that valid and its address, length or data hold steady.
- R9: No more than MAX_OUTSTANDING (default 4) bursts are awaiting a write response. `wr_idle` is high only with no open group, no burst in flight and no response outstanding.
- R10: Any `m_bresp` other than OKAY (2'b00) sets `wr_error`, which stays high until reset. `wr_done` equals `wr_idle` with `wr_error` low.
- R11: A change of `cfg_base` while a group is open does not move that group. The new base applies from the next group.
- R12: After reset, `pix_ready`, `wr_idle` and `wr_done` are high, while `wr_error`, `m_awvalid` and `m_wvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | ADDR_W | Framebuffer base byte address, sampled at group start |
| cfg_idle_cycles | input | IDLE_W | Idle cycles before an open group is flushed |
| pix_valid | input | 1 | Pixel present |
| pix_ready | output | 1 | Pixel accepted this cycle when valid is also high |
| pix_index | input | INDEX_W | Linear pixel position in the frame |
| pix_rgb | input | 32 | Packed colour word |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Burst start address |
| m_awlen | output | 8 | Beats minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type code |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready (always high) |
| m_bresp | input | 2 | Write response code |
| wr_idle | output | 1 | Nothing pending anywhere |
| wr_done | output | 1 | Idle with no error seen |
| wr_error | output | 1 | Sticky error-response flag |

## Verification
The assertions check the cycle-level channel rules on every cycle:
- address and data stay put while they wait for ready,
- each burst stays inside one page and within the beat limit,
- the last-beat marker sits on the right beat,
- the count of unanswered bursts stays within its cap,
- the error flag never falls,
- an open group stays frozen while it is being issued.

Only the bench scenarios can show which bursts the pixel stream should have produced. They cover how runs merge and split, where a base change lands, and whether the idle flush waits the programmed time. A scoreboard fed from a bench model of the grouping rules compares every address, length and data word against those expectations.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
   localparam logic [1:0] AXI_BURST_INCR = 2'b01;
   localparam logic [1:0] AXI_RESP_OKAY  = 2'b00;
   localparam logic [2:0] AXI_SIZE_WORD  = 3'b010;

   typedef enum logic [1:0] {
      ISS_IDLE = 2'd0,
      ISS_ADDR = 2'd1,
      ISS_DATA = 2'd2
   } iss_state_e;
endpackage

// File: rtl/fbw_gather.sv
// Collects a run of successive pixel indices into one pending group and
// decides when the group must be handed to the burst issuer.
module fbw_gather #(
   parameter int ADDR_W     = 32,
   parameter int INDEX_W    = 20,
   parameter int MAX_BEATS  = 16,
   parameter int PAGE_BYTES = 4096,
   parameter int IDLE_W     = 16
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                cfg_base,
   input  logic [IDLE_W-1:0]                cfg_idle_cycles,
   input  logic                             pix_valid,
   output logic                             pix_ready,
   input  logic [INDEX_W-1:0]               pix_index,
   input  logic [31:0]                      pix_rgb,
   output logic                             grp_req,
   output logic [ADDR_W-1:0]                grp_addr,
   output logic [7:0]                       grp_len,
   input  logic                             grp_done,
   input  logic [$clog2(MAX_BEATS)-1:0]     rd_idx,
   output logic [31:0]                      rd_data,
   output logic                             grp_empty
);
   localparam int CNT_W  = $clog2(MAX_BEATS + 1);
   localparam int BEAT_W = $clog2(MAX_BEATS);
   localparam int PAGE_W = $clog2(PAGE_BYTES);

   logic [31:0]        mem [MAX_BEATS];
   logic [CNT_W-1:0]   cnt;
   logic [ADDR_W-1:0]  start_addr;
   logic [INDEX_W-1:0] last_idx;
   logic [IDLE_W-1:0]  idle_cnt;
   logic               busy;

   logic [ADDR_W-1:0]  next_addr;
   logic               full, page_end, follows, joins, accept, timeout, close;

   always_comb begin
      next_addr = start_addr + ADDR_W'({cnt, 2'b00});
      full      = (cnt == CNT_W'(MAX_BEATS));
      page_end  = (cnt != '0) && (next_addr[PAGE_W-1:0] == '0);
      follows   = (pix_index == last_idx + INDEX_W'(1));
      joins     = (cnt != '0) && follows && !full && !page_end;
      pix_ready = !busy && ((cnt == '0) || joins);
      accept    = pix_valid && pix_ready;
      timeout   = (idle_cnt >= cfg_idle_cycles);
      close     = !busy && (cnt != '0) &&
                  (full || page_end || (pix_valid ? !joins : timeout));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt        <= '0;
         busy       <= 1'b0;
         start_addr <= '0;
         last_idx   <= '0;
         idle_cnt   <= '0;
      end else if (busy) begin
         if (grp_done) begin
            busy     <= 1'b0;
            cnt      <= '0;
            idle_cnt <= '0;
         end
      end else if (accept) begin
         if (cnt == '0)
            start_addr <= cfg_base + ADDR_W'({pix_index, 2'b00});
         cnt      <= cnt + CNT_W'(1);
         last_idx <= pix_index;
         idle_cnt <= '0;
      end else if (close) begin
         busy <= 1'b1;
      end else if ((cnt != '0) && (idle_cnt != '1)) begin
         idle_cnt <= idle_cnt + IDLE_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (accept)
         mem[cnt[BEAT_W-1:0]] <= pix_rgb;
   end

   assign grp_req   = busy;
   assign grp_addr  = start_addr;
   assign grp_len   = 8'(cnt - CNT_W'(1));
   assign rd_data   = mem[rd_idx];
   assign grp_empty = (cnt == '0) && !busy;

   // R2: a group handed to the issuer must not change until the issuer ends it
   p_group_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_req && !grp_done) |=> (grp_req && $stable(grp_len) && $stable(grp_addr)));

   // R4: the group never grows beyond the beat limit
   p_group_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      grp_req |-> (int'(grp_len) < MAX_BEATS));
endmodule

// File: rtl/fbw_issue.sv
// Drives the address and data channels for one pending group at a time.
module fbw_issue
   import fbw_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int MAX_BEATS  = 16,
   parameter int PAGE_BYTES = 4096
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         grp_req,
   input  logic [ADDR_W-1:0]            grp_addr,
   input  logic [7:0]                   grp_len,
   output logic                         grp_done,
   output logic [$clog2(MAX_BEATS)-1:0] rd_idx,
   input  logic [31:0]                  rd_data,
   input  logic                         can_issue,
   output logic                         aw_fire,
   output logic                         m_awvalid,
   input  logic                         m_awready,
   output logic [ADDR_W-1:0]            m_awaddr,
   output logic [7:0]                   m_awlen,
   output logic [2:0]                   m_awsize,
   output logic [1:0]                   m_awburst,
   output logic                         m_wvalid,
   input  logic                         m_wready,
   output logic [31:0]                  m_wdata,
   output logic [3:0]                   m_wstrb,
   output logic                         m_wlast
);
   localparam int BEAT_W = $clog2(MAX_BEATS);
   localparam int PAGE_W = $clog2(PAGE_BYTES);

   iss_state_e state;
   logic [7:0] beat;

   always_comb begin
      m_awvalid = (state == ISS_ADDR);
      m_awaddr  = grp_addr;
      m_awlen   = grp_len;
      m_awsize  = AXI_SIZE_WORD;
      m_awburst = AXI_BURST_INCR;
      m_wvalid  = (state == ISS_DATA);
      m_wdata   = rd_data;
      m_wstrb   = 4'hF;
      m_wlast   = m_wvalid && (beat == grp_len);
      rd_idx    = beat[BEAT_W-1:0];
      aw_fire   = m_awvalid && m_awready;
      grp_done  = m_wvalid && m_wready && m_wlast;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ISS_IDLE;
         beat  <= '0;
      end else begin
         unique case (state)
            ISS_IDLE: if (grp_req && can_issue) state <= ISS_ADDR;
            ISS_ADDR: if (m_awready) begin
               state <= ISS_DATA;
               beat  <= '0;
            end
            ISS_DATA: if (m_wready) begin
               if (m_wlast) state <= ISS_IDLE;
               else         beat  <= beat + 8'd1;
            end
            default: state <= ISS_IDLE;
         endcase
      end
   end

   // Independent beat counter used only by the checks below
   logic [7:0] chk_len;
   logic [8:0] chk_beats;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_len   <= '0;
         chk_beats <= '0;
      end else if (aw_fire) begin
         chk_len   <= m_awlen;
         chk_beats <= '0;
      end else if (m_wvalid && m_wready) begin
         chk_beats <= m_wlast ? 9'd0 : chk_beats + 9'd1;
      end
   end

   p_wlast_final_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && m_wready && m_wlast) |-> (chk_beats == {1'b0, chk_len}));
   p_wlast_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && m_wready && !m_wlast) |-> (chk_beats < {1'b0, chk_len}));
   p_aw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr) && $stable(m_awlen)));
   p_w_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wlast)));
   p_no_page_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid |-> ((int'(m_awaddr[PAGE_W-1:2]) + int'(m_awlen)) < (PAGE_BYTES / 4)));
   p_beat_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      m_awvalid |-> (int'(m_awlen) < MAX_BEATS));
endmodule

// File: rtl/fbw_resp_track.sv
// Counts bursts awaiting a write response and records error responses.
module fbw_resp_track
   import fbw_pkg::*;
#(
   parameter int MAX_OUT = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       aw_fire,
   input  logic       b_fire,
   input  logic [1:0] bresp,
   output logic       can_issue,
   output logic       none_pending,
   output logic       err_sticky
);
   localparam int OUT_W = $clog2(MAX_OUT + 1);

   logic [OUT_W-1:0] pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend       <= '0;
         err_sticky <= 1'b0;
      end else begin
         pend <= pend + OUT_W'(aw_fire) - OUT_W'(b_fire);
         if (b_fire && (bresp != AXI_RESP_OKAY))
            err_sticky <= 1'b1;
      end
   end

   assign can_issue    = (pend < OUT_W'(MAX_OUT));
   assign none_pending = (pend == '0);

   p_pend_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pend) <= MAX_OUT);
   p_no_stray_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      b_fire |-> (pend != '0));
   p_err_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_sticky |=> err_sticky);
endmodule

// File: rtl/fb_burst_writer.sv
module fb_burst_writer #(
   parameter int ADDR_W          = 32,
   parameter int INDEX_W         = 20,
   parameter int MAX_BEATS       = 16,
   parameter int PAGE_BYTES      = 4096,
   parameter int IDLE_W          = 16,
   parameter int MAX_OUTSTANDING = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  cfg_base,
   input  logic [IDLE_W-1:0]  cfg_idle_cycles,
   input  logic               pix_valid,
   output logic               pix_ready,
   input  logic [INDEX_W-1:0] pix_index,
   input  logic [31:0]        pix_rgb,
   output logic               m_awvalid,
   input  logic               m_awready,
   output logic [ADDR_W-1:0]  m_awaddr,
   output logic [7:0]         m_awlen,
   output logic [2:0]         m_awsize,
   output logic [1:0]         m_awburst,
   output logic               m_wvalid,
   input  logic               m_wready,
   output logic [31:0]        m_wdata,
   output logic [3:0]         m_wstrb,
   output logic               m_wlast,
   input  logic               m_bvalid,
   output logic               m_bready,
   input  logic [1:0]         m_bresp,
   output logic               wr_idle,
   output logic               wr_done,
   output logic               wr_error
);
   localparam int BEAT_W = $clog2(MAX_BEATS);

   // Elaboration-time parameter checks
   if (MAX_BEATS < 2 || MAX_BEATS > 256) begin : g_bad_beats
      $error("MAX_BEATS must lie in 2..256");
   end
   if (PAGE_BYTES < 4 * MAX_BEATS || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two holding a full burst");
   end
   if (ADDR_W < INDEX_W + 2) begin : g_bad_addr
      $error("ADDR_W too narrow for INDEX_W");
   end
   if (MAX_OUTSTANDING < 1) begin : g_bad_out
      $error("MAX_OUTSTANDING must be at least 1");
   end

   logic              grp_req, grp_done, grp_empty, can_issue, aw_fire;
   logic              none_pending;
   logic [ADDR_W-1:0] grp_addr;
   logic [7:0]        grp_len;
   logic [BEAT_W-1:0] rd_idx;
   logic [31:0]       rd_data;

   fbw_gather #(
      .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .MAX_BEATS(MAX_BEATS),
      .PAGE_BYTES(PAGE_BYTES), .IDLE_W(IDLE_W)
   ) u_gather (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base),
      .cfg_idle_cycles(cfg_idle_cycles), .pix_valid(pix_valid),
      .pix_ready(pix_ready), .pix_index(pix_index), .pix_rgb(pix_rgb),
      .grp_req(grp_req), .grp_addr(grp_addr), .grp_len(grp_len),
      .grp_done(grp_done), .rd_idx(rd_idx), .rd_data(rd_data),
      .grp_empty(grp_empty)
   );

   fbw_issue #(
      .ADDR_W(ADDR_W), .MAX_BEATS(MAX_BEATS), .PAGE_BYTES(PAGE_BYTES)
   ) u_issue (
      .clk(clk), .rst_n(rst_n), .grp_req(grp_req), .grp_addr(grp_addr),
      .grp_len(grp_len), .grp_done(grp_done), .rd_idx(rd_idx),
      .rd_data(rd_data), .can_issue(can_issue), .aw_fire(aw_fire),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
      .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
      .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
      .m_wstrb(m_wstrb), .m_wlast(m_wlast)
   );

   fbw_resp_track #(.MAX_OUT(MAX_OUTSTANDING)) u_resp (
      .clk(clk), .rst_n(rst_n), .aw_fire(aw_fire),
      .b_fire(m_bvalid && m_bready), .bresp(m_bresp),
      .can_issue(can_issue), .none_pending(none_pending),
      .err_sticky(wr_error)
   );

   assign m_bready = 1'b1;
   assign wr_idle  = grp_empty && none_pending;
   assign wr_done  = wr_idle && !wr_error;

   // R9: reported idle means no channel activity is left
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_idle |-> (!m_awvalid && !m_wvalid));
   // R1: with a word-aligned base every burst address is word aligned
   p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && (cfg_base[1:0] == 2'b00) && $stable(cfg_base)) |-> (m_awaddr[1:0] == 2'b00));
endmodule

// File: tb/tb_fb_burst_writer.sv
`timescale 1ns/1ps
module tb_fb_burst_writer;
   localparam int ADDR_W = 32;
   localparam int INDEX_W = 20;
   localparam int IDLE_W = 16;
   localparam int MAXB = 16;
   localparam int MAXO = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [ADDR_W-1:0] cfg_base = 32'h1000_0000;
   logic [IDLE_W-1:0] cfg_idle_cycles = 16'd8;
   logic pix_valid = 1'b0;
   logic pix_ready;
   logic [INDEX_W-1:0] pix_index = '0;
   logic [31:0] pix_rgb = '0;
   logic m_awvalid, m_awready = 1'b0;
   logic [ADDR_W-1:0] m_awaddr;
   logic [7:0] m_awlen;
   logic [2:0] m_awsize;
   logic [1:0] m_awburst;
   logic m_wvalid, m_wready = 1'b0;
   logic [31:0] m_wdata;
   logic [3:0] m_wstrb;
   logic m_wlast;
   logic m_bvalid = 1'b0, m_bready;
   logic [1:0] m_bresp = 2'b00;
   logic wr_idle, wr_done, wr_error;

   fb_burst_writer dut (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_idle_cycles(cfg_idle_cycles),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_index(pix_index), .pix_rgb(pix_rgb),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
      .m_awsize(m_awsize), .m_awburst(m_awburst), .m_wvalid(m_wvalid), .m_wready(m_wready),
      .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid),
      .m_bready(m_bready), .m_bresp(m_bresp), .wr_idle(wr_idle), .wr_done(wr_done),
      .wr_error(wr_error)
   );

   always #2.5 clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_cmp = 0, n_bad = 0;
   bit finished = 0;

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Scoreboard queues
   logic [31:0] exp_addr_q[$];
   logic [7:0]  exp_len_q[$];
   logic [31:0] exp_data_q[$];
   logic [1:0]  b_pend_q[$];

   // Bench model of the grouping rules
   int unsigned m_cnt = 0;
   logic [31:0] m_start = '0;
   logic [INDEX_W-1:0] m_last = '0;

   task automatic model_close();
      if (m_cnt > 0) begin
         exp_addr_q.push_back(m_start);
         exp_len_q.push_back(8'(m_cnt - 1));
         m_cnt = 0;
      end
   endtask

   int unsigned acc_cyc = 0;

   // Called right after a falling edge; returns right after a falling edge
   task automatic send(logic [INDEX_W-1:0] idx, logic [31:0] rgb);
      logic [31:0] nxt;
      if (!(m_cnt > 0 && idx == m_last + 1)) begin
         model_close();
         m_start = cfg_base + {idx, 2'b00};
      end
      m_cnt++;
      m_last = idx;
      exp_data_q.push_back(rgb);
      nxt = m_start + 32'(m_cnt * 4);
      if (m_cnt == MAXB || nxt[11:0] == 12'h000) model_close();
      pix_valid = 1'b1;
      pix_index = idx;
      pix_rgb   = rgb;
      forever begin
         #1;
         if (pix_ready) begin
            acc_cyc = cyc + 1;
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic settle(string req);
      bit ok = 0;
      pix_valid = 1'b0;
      model_close();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         #1;
         if (wr_idle && exp_addr_q.size() == 0 && exp_data_q.size() == 0 && b_pend_q.size() == 0) begin
            ok = 1;
            break;
         end
      end
      chk(ok, req, "drain to idle", exp_addr_q.size(), 0);
      chk(wr_done == !wr_error, "R10", "done vs error", wr_done, !wr_error);
      @(negedge clk);
   endtask

   // Slave model and monitor
   bit aw_slow = 0, w_slow = 0, err_next = 0;
   int unsigned b_div = 1;
   int outstanding = 0, max_out = 0;
   logic [7:0] cur_len = '0;
   int unsigned beat = 0;
   int unsigned aw_cyc = 0;
   logic [31:0] cur_addr = '0;

   initial begin
      forever begin
         @(negedge clk);
         m_awready = aw_slow ? cyc[0] : 1'b1;
         m_wready  = w_slow ? (cyc[1:0] != 2'b00) : 1'b1;
         m_bvalid  = (b_pend_q.size() > 0) && (cyc % b_div == 0);
         m_bresp   = m_bvalid ? b_pend_q[0] : 2'b00;
         #1;
         if (rst_n && m_awvalid && m_awready) begin
            aw_cyc = cyc + 1;
            if (exp_addr_q.size() == 0) chk(0, "R3", "unexpected burst", m_awaddr, 0);
            else begin
               logic [31:0] ea;
               logic [7:0] el;
               ea = exp_addr_q.pop_front();
               el = exp_len_q.pop_front();
               chk(m_awaddr == ea, "R1", "burst address", m_awaddr, ea);
               chk(m_awlen == el, "R2", "burst length", m_awlen, el);
            end
            chk(m_awsize == 3'b010 && m_awburst == 2'b01, "R1", "size/burst type",
                {m_awsize, m_awburst}, 5'b01001);
            cur_len = m_awlen;
            cur_addr = m_awaddr;
            beat = 0;
            outstanding++;
            if (outstanding > max_out) max_out = outstanding;
            chk(outstanding <= MAXO, "R9", "outstanding cap", outstanding, MAXO);
         end
         if (rst_n && m_wvalid && m_wready) begin
            if (exp_data_q.size() == 0) chk(0, "R3", "unexpected beat", m_wdata, 0);
            else begin
               logic [31:0] ed;
               ed = exp_data_q.pop_front();
               chk(m_wdata == ed, "R3", "beat data", m_wdata, ed);
            end
            chk(m_wlast == (beat == cur_len), "R7", "wlast placement", m_wlast, beat == cur_len);
            chk(m_wstrb == 4'hF, "R1", "strobes", m_wstrb, 4'hF);
            beat++;
            if (m_wlast) begin
               b_pend_q.push_back(err_next ? 2'b10 : 2'b00);
               err_next = 0;
            end
         end
         if (m_bvalid && m_bready) begin
            void'(b_pend_q.pop_front());
            outstanding--;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R12: reset state
      chk(pix_ready == 1'b1, "R12", "pix_ready", pix_ready, 1);
      chk(!m_awvalid && !m_wvalid, "R12", "channels quiet", {m_awvalid, m_wvalid}, 0);
      chk(wr_idle && wr_done && !wr_error, "R12", "status", {wr_idle, wr_done, wr_error}, 3'b110);
      @(negedge clk);

      // R2: a short consecutive run becomes one burst
      for (int i = 0; i < 5; i++) send(20'(40 + i), 32'hA000_0000 + 32'(i));
      settle("R2");

      // R3: scattered order, slow response path exercises R9 cap
      b_div = 12;
      aw_slow = 1;
      send(20'd100, 32'hB100); send(20'd7, 32'hB007); send(20'd300, 32'hB300);
      send(20'd301, 32'hB301); send(20'd50, 32'hB050); send(20'd900, 32'hB900);
      send(20'd2, 32'hB002); send(20'd640, 32'hB640); send(20'd11, 32'hB011);
      settle("R3");
      chk(max_out == MAXO, "R9", "cap reached under slow responses", max_out, MAXO);
      b_div = 1;
      aw_slow = 0;

      // R4: long run splits at the beat limit
      w_slow = 1;
      for (int i = 0; i < 20; i++) send(20'(2000 + i), 32'hC000_0000 + 32'(i));
      settle("R4");
      w_slow = 0;

      // R5: run straddling a page boundary splits at the page
      for (int i = 0; i < 8; i++) send(20'(1020 + i), 32'hD000_0000 + 32'(i));
      settle("R5");

      // R11: base change inside an open group applies to the next group
      send(20'd10, 32'hE010); send(20'd11, 32'hE011);
      cfg_base = 32'h2000_0000;
      send(20'd12, 32'hE012); send(20'd13, 32'hE013);
      settle("R11");
      send(20'd200, 32'hE200);
      settle("R11");

      // R6: idle flush waits for the programmed number of cycles
      cfg_idle_cycles = 16'd40;
      send(20'd500, 32'hF500);
      pix_valid = 1'b0;
      model_close();
      settle("R6");
      chk(aw_cyc - acc_cyc >= 40, "R6", "flush not before idle limit", aw_cyc - acc_cyc, 40);
      chk(aw_cyc - acc_cyc <= 60, "R6", "flush soon after idle limit", aw_cyc - acc_cyc, 60);
      cfg_idle_cycles = 16'd8;

      // R10: error response sets a sticky flag
      chk(wr_error == 1'b0, "R10", "no error before injection", wr_error, 0);
      err_next = 1;
      send(20'd77, 32'h1077);
      settle("R10");
      #1;
      chk(wr_error == 1'b1, "R10", "error flag set", wr_error, 1);
      chk(wr_idle && !wr_done, "R10", "idle but not done", {wr_idle, wr_done}, 2'b10);
      send(20'd78, 32'h1078); send(20'd90, 32'h1090);
      settle("R10");
      #1;
      chk(wr_error == 1'b1, "R10", "error stays after clean bursts", wr_error, 1);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule